// File: doc/BRIEF.md
# Double-and-Add Scalar Multiplication Sequencer

This block computes a scalar multiple Q = k·P of a base point. A 32-bit scalar k is scanned from its top bit down to bit 0. For every bit the running result is doubled first, and the base point is then added only when that bit is one. Each group operation is handed to a point-operation unit through a request/acknowledge handshake. The sequencer waits for the acknowledge before it moves on, so the point unit's latency can be set freely.

The running result carries an identity flag, so the point at infinity needs no special coordinate value. Doubling the identity leaves the identity and costs no operation. The first one bit of the scalar loads the base point directly. For checking, the point unit is a parameterized stand-in: the additive group of pairs of W-bit integers modulo 2^W. In that group doubling multiplies each coordinate by two, adding the base point adds it coordinate-wise, and k·P is easy to predict.

A user presents the base point and the scalar and pulses `start`. When `done` rises, the result coordinates and the identity flag are valid. They stay that way until the next start.

Top module: `kpm_scalar_mult`

## Requirements
- R1: After reset, `done` is 0, `res_inf` is 1, and `res_x` and `res_y` are 0.
- R2: When `start` is sampled high while the block is idle or finished, the block later reports `res_x = (k·base_x) mod 2^W` and `res_y = (k·base_y) mod 2^W`. The stand-in unit doubles a coordinate as 2·c mod 2^W and adds the base point as c + base mod 2^W.
- R3: The scalar is scanned from bit 31 to bit 0, one bit per step. With operation latency L, `done` rises this many clock edges after the edge that samples `start`: one edge for each bit from bit 31 down to and including the highest set bit, L+2 edges for each lower zero bit (a double), and 2L+4 edges for each lower one bit (a double then an add).
- R4: A scalar of zero gives `res_inf` = 1 and coordinates 0. `done` rises exactly 32 edges after the start edge, and no point operation is issued.
- R5: The identity flag is cleared only by the first one bit, which loads the base point without an operation. It stays cleared even if later arithmetic wraps both coordinates to zero.
- R6: At most one point operation is outstanding. A request is issued only while the unit is idle, and each acknowledge is a single-cycle pulse that the sequencer waits for.
- R7: Once `done` is high, it stays high and the result outputs stay unchanged until the next accepted start.
- R8: A `start` pulse while a computation is running is ignored. The running result and its timing are unaffected.
- R9: A start accepted while `done` is high brings `done` low on the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation when idle or finished |
| base_x | input | W | Base point X coordinate |
| base_y | input | W | Base point Y coordinate |
| key | input | KEY_W | Scalar k |
| res_x | output | W | Result X coordinate |
| res_y | output | W | Result Y coordinate |
| res_inf | output | 1 | Result is the identity (point at infinity) |
| done | output | 1 | Result valid; held until the next start |

## Verification
A wrong bit order, a missing double, or a wrongly taken add changes the result coordinates at `done`. The scalar's weighting of the base point comes out wrong, so it shows as soon as the run finishes. The same mistakes also move the completion time away from the per-bit cycle formula. An identity flag that is handled wrongly shows in two ways: zero-scalar and single-bit runs finish late, and `res_inf` is wrong when the coordinates wrap to zero. Handshake slips stall the run and trip the bench timeout, or they corrupt the result of that same run.

// File: rtl/kpm_pkg.sv
package kpm_pkg;

    localparam int DEF_KEY_W = 32;

    typedef enum logic {
        OP_DBL = 1'b0,
        OP_ADD = 1'b1
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_SCAN      = 3'd1,
        S_DBL_WAIT  = 3'd2,
        S_ADD_ISSUE = 3'd3,
        S_ADD_WAIT  = 3'd4,
        S_DONE      = 3'd5
    } seq_state_e;

    function automatic logic is_running(input seq_state_e s);
        return (s != S_IDLE) && (s != S_DONE);
    endfunction

endpackage

// File: rtl/kpm_point_unit.sv
module kpm_point_unit
    import kpm_pkg::*;
#(
    parameter int W      = 16,
    parameter int OP_LAT = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req,
    input  op_e          op,
    input  logic [W-1:0] acc_x,
    input  logic [W-1:0] acc_y,
    input  logic [W-1:0] base_x,
    input  logic [W-1:0] base_y,
    output logic         ack,
    output logic [W-1:0] out_x,
    output logic [W-1:0] out_y
);

    localparam int NCOORD = 2;
    localparam int CNT_W  = (OP_LAT > 1) ? $clog2(OP_LAT) : 1;

    logic [NCOORD-1:0][W-1:0] acc_c;
    logic [NCOORD-1:0][W-1:0] base_c;
    logic [NCOORD-1:0][W-1:0] next_c;
    logic [NCOORD-1:0][W-1:0] res_q;
    logic                     busy;
    logic [CNT_W-1:0]         cnt;

    assign acc_c[0]  = acc_x;
    assign acc_c[1]  = acc_y;
    assign base_c[0] = base_x;
    assign base_c[1] = base_y;

    for (genvar g = 0; g < NCOORD; g++) begin : g_coord
        always_comb begin
            if (op == OP_DBL) next_c[g] = acc_c[g] + acc_c[g];
            else              next_c[g] = acc_c[g] + base_c[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            ack   <= 1'b0;
            res_q <= '0;
        end else begin
            ack <= 1'b0;
            if (busy) begin
                if (cnt == '0) begin
                    busy <= 1'b0;
                    ack  <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (req) begin
                busy  <= 1'b1;
                cnt   <= CNT_W'(OP_LAT - 1);
                res_q <= next_c;
            end
        end
    end

    assign out_x = res_q[0];
    assign out_y = res_q[1];

    // R6: a new request never arrives while an operation is in flight
    p_one_outstanding_r6: assert property (@(posedge clk) disable iff (rst)
        req |-> !busy);

    // R6: acknowledge is a single-cycle pulse
    p_ack_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

endmodule

// File: rtl/kpm_scan_ctrl.sv
module kpm_scan_ctrl
    import kpm_pkg::*;
#(
    parameter int W     = 16,
    parameter int KEY_W = DEF_KEY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [W-1:0]     base_x,
    input  logic [W-1:0]     base_y,
    input  logic [KEY_W-1:0] key,
    output logic             req,
    output op_e              op,
    output logic [W-1:0]     opnd_x,
    output logic [W-1:0]     opnd_y,
    output logic [W-1:0]     pt_x,
    output logic [W-1:0]     pt_y,
    input  logic             ack,
    input  logic [W-1:0]     unit_x,
    input  logic [W-1:0]     unit_y,
    output logic [W-1:0]     res_x,
    output logic [W-1:0]     res_y,
    output logic             res_inf,
    output logic             done
);

    localparam int IDX_W = $clog2(KEY_W);

    seq_state_e        state;
    logic [KEY_W-1:0]  key_q;
    logic [W-1:0]      bx_q, by_q;
    logic [W-1:0]      acc_x, acc_y;
    logic              acc_inf;
    logic [IDX_W-1:0]  idx;
    logic              bit_now;
    logic              last_bit;
    logic              running;

    assign bit_now  = key_q[idx];
    assign last_bit = (idx == '0);
    assign running  = is_running(state);

    always_comb begin
        req = 1'b0;
        op  = OP_DBL;
        if (state == S_SCAN && !acc_inf) begin
            req = 1'b1;
            op  = OP_DBL;
        end else if (state == S_ADD_ISSUE) begin
            req = 1'b1;
            op  = OP_ADD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            key_q   <= '0;
            bx_q    <= '0;
            by_q    <= '0;
            acc_x   <= '0;
            acc_y   <= '0;
            acc_inf <= 1'b1;
            idx     <= '0;
        end else begin
            unique case (state)
                S_IDLE, S_DONE: begin
                    if (start) begin
                        key_q   <= key;
                        bx_q    <= base_x;
                        by_q    <= base_y;
                        acc_x   <= '0;
                        acc_y   <= '0;
                        acc_inf <= 1'b1;
                        idx     <= IDX_W'(KEY_W - 1);
                        state   <= S_SCAN;
                    end
                end
                S_SCAN: begin
                    if (acc_inf) begin
                        if (bit_now) begin
                            acc_x   <= bx_q;
                            acc_y   <= by_q;
                            acc_inf <= 1'b0;
                        end
                        if (last_bit) state <= S_DONE;
                        else          idx   <= idx - 1'b1;
                    end else begin
                        state <= S_DBL_WAIT;
                    end
                end
                S_DBL_WAIT: begin
                    if (ack) begin
                        acc_x <= unit_x;
                        acc_y <= unit_y;
                        if (bit_now) begin
                            state <= S_ADD_ISSUE;
                        end else if (last_bit) begin
                            state <= S_DONE;
                        end else begin
                            idx   <= idx - 1'b1;
                            state <= S_SCAN;
                        end
                    end
                end
                S_ADD_ISSUE: state <= S_ADD_WAIT;
                S_ADD_WAIT: begin
                    if (ack) begin
                        acc_x <= unit_x;
                        acc_y <= unit_y;
                        if (last_bit) begin
                            state <= S_DONE;
                        end else begin
                            idx   <= idx - 1'b1;
                            state <= S_SCAN;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign opnd_x  = acc_x;
    assign opnd_y  = acc_y;
    assign pt_x    = bx_q;
    assign pt_y    = by_q;
    assign res_x   = acc_x;
    assign res_y   = acc_y;
    assign res_inf = acc_inf;
    assign done    = (state == S_DONE);

    // R5: the identity is never handed to the point unit
    p_inf_no_op_r5: assert property (@(posedge clk) disable iff (rst)
        req |-> !acc_inf);

    // R6: acknowledges arrive only while the sequencer waits for one
    p_ack_in_wait_r6: assert property (@(posedge clk) disable iff (rst)
        ack |-> (state == S_DBL_WAIT || state == S_ADD_WAIT));

    // R7: done and the result hold until a new start
    p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(res_x) && $stable(res_y) && $stable(res_inf)));

    // R8: a start during a run leaves the captured scalar alone
    p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (running && start) |=> $stable(key_q));

    // R9: an accepted start from the finished state drops done
    p_restart_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> !done);

endmodule

// File: rtl/kpm_scalar_mult.sv
module kpm_scalar_mult
    import kpm_pkg::*;
#(
    parameter int W      = 16,
    parameter int KEY_W  = DEF_KEY_W,
    parameter int OP_LAT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [W-1:0]     base_x,
    input  logic [W-1:0]     base_y,
    input  logic [KEY_W-1:0] key,
    output logic [W-1:0]     res_x,
    output logic [W-1:0]     res_y,
    output logic             res_inf,
    output logic             done
);

    logic         req;
    op_e          op;
    logic [W-1:0] opnd_x, opnd_y, pt_x, pt_y;
    logic         ack;
    logic [W-1:0] unit_x, unit_y;

    kpm_scan_ctrl #(.W(W), .KEY_W(KEY_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .base_x  (base_x),
        .base_y  (base_y),
        .key     (key),
        .req     (req),
        .op      (op),
        .opnd_x  (opnd_x),
        .opnd_y  (opnd_y),
        .pt_x    (pt_x),
        .pt_y    (pt_y),
        .ack     (ack),
        .unit_x  (unit_x),
        .unit_y  (unit_y),
        .res_x   (res_x),
        .res_y   (res_y),
        .res_inf (res_inf),
        .done    (done)
    );

    kpm_point_unit #(.W(W), .OP_LAT(OP_LAT)) u_unit (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .op     (op),
        .acc_x  (opnd_x),
        .acc_y  (opnd_y),
        .base_x (pt_x),
        .base_y (pt_y),
        .ack    (ack),
        .out_x  (unit_x),
        .out_y  (unit_y)
    );

endmodule

// File: tb/tb_kpm_scalar_mult.sv
module tb_kpm_scalar_mult;

    localparam int W   = 16;
    localparam int KW  = 32;
    localparam int LAT = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [W-1:0]  base_x, base_y;
    logic [KW-1:0] key;
    logic [W-1:0]  res_x, res_y;
    logic          res_inf, done;

    int n_checks = 0;
    int n_fail   = 0;

    kpm_scalar_mult #(.W(W), .KEY_W(KW), .OP_LAT(LAT)) dut (
        .clk(clk), .rst(rst), .start(start),
        .base_x(base_x), .base_y(base_y), .key(key),
        .res_x(res_x), .res_y(res_y), .res_inf(res_inf), .done(done)
    );

    always #4 clk = ~clk;

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_lat(input logic [KW-1:0] k);
        int total = 0;
        logic seen = 1'b0;
        for (int i = KW - 1; i >= 0; i--) begin
            if (!seen) begin
                total++;
                if (k[i]) seen = 1'b1;
            end else begin
                total += k[i] ? (2 * LAT + 4) : (LAT + 2);
            end
        end
        return total;
    endfunction

    function automatic logic [W-1:0] mulmod(input logic [KW-1:0] k, input logic [W-1:0] p);
        logic [63:0] prod = 64'(k) * 64'(p);
        return prod[W-1:0];
    endfunction

    // Starts a run, counts edges to done and checks the outcome.
    // busy_key: if nonzero, a start with that key is pulsed mid-run (R8).
    task automatic run(input logic [KW-1:0] k, input logic [W-1:0] px, input logic [W-1:0] py,
                       input logic [KW-1:0] busy_key);
        int n = 0;
        @(negedge clk);
        start = 1'b1; key = k; base_x = px; base_y = py;
        @(posedge clk);
        #1;
        start = 1'b0;
        key = '1; base_x = '1; base_y = '1;
        check(done == 1'b0, "R9 done low after start", done, 0);
        while (!done && n < 2000) begin
            @(posedge clk);
            #2;
            n++;
            if (busy_key != '0 && n == 10) begin
                start = 1'b1; key = busy_key;
                @(posedge clk);
                #2;
                n++;
                start = 1'b0;
            end
        end
        check(n == exp_lat(k), "R3 latency", n, exp_lat(k));
        check(res_x == mulmod(k, px), "R2 res_x", res_x, mulmod(k, px));
        check(res_y == mulmod(k, py), "R2 res_y", res_y, mulmod(k, py));
        check(res_inf == (k == '0), "R5 res_inf", res_inf, (k == '0));
    endtask

    initial begin
        #1200000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        logic [W-1:0] hx, hy;
        logic         hinf;
        rst = 1'b1; start = 1'b0; key = '0; base_x = '0; base_y = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #2;
        // R1 reset state
        check(done == 1'b0, "R1 done", done, 0);
        check(res_inf == 1'b1, "R1 res_inf", res_inf, 1);
        check(res_x == '0 && res_y == '0, "R1 coords", res_x, 0);

        // R4 zero scalar: identity, 32 edges, no operation
        run(32'h0, 16'h1234, 16'h0BCD, '0);
        check(res_inf && res_x == '0, "R4 zero key identity", res_inf, 1);

        // R5 single high bit loads base point without an operation
        run(32'h1, 16'hA5A5, 16'h0F0F, '0);
        run(32'h2, 16'h8000, 16'h4000, '0);   // R5 wrap to zero keeps flag clear
        check(res_x == '0 && res_y == 16'h8000 && !res_inf, "R5 wrap", res_x, 0);
        run(32'h3, 16'h0007, 16'h0011, '0);
        run(32'h8000_0000, 16'h0001, 16'h0003, '0);
        run(32'hFFFF_FFFF, 16'h1357, 16'h2468, '0);

        for (int i = 0; i < KW; i++)
            run(32'h1 << i, 16'(i * 37 + 5), 16'(i * 91 + 1), '0);

        lfsr = 32'hACE1_1234;
        for (int j = 0; j < 24; j++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            run(lfsr, lfsr[15:0] ^ 16'h5A3C, lfsr[31:16], '0);
        end

        // R8 start during a run is ignored
        run(32'h0000_00F5, 16'h0321, 16'h0777, 32'hFFFF_FFFF);

        // R7 done and result hold
        hx = res_x; hy = res_y; hinf = res_inf;
        repeat (10) @(posedge clk);
        #2;
        check(done == 1'b1, "R7 done held", done, 1);
        check(res_x == hx && res_y == hy && res_inf == hinf, "R7 result held", res_x, hx);

        // R9 restart from done
        run(32'h0000_0005, 16'h0002, 16'h0003, '0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule